// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block is the status and control register for one port of a high-speed USB host controller. Software writes a 32-bit word to it and reads back a 32-bit word. The block turns those writes, and a few controller-wide and line-level inputs, into the signals that drive the port: the power switch, the bus-reset request, suspend, wake-on-connect, the test-mode select, and the flag that hands the port to a companion controller.

A four-state machine holds the port's activity: unpowered, idle, bus reset, or suspended. Port ownership and port power each live in a register of their own. The transitions of the state machine are as follows. `ST_OFF` goes to `ST_IDLE` when power comes on. `ST_IDLE`, `ST_SUSPENDED` and `ST_BUS_RESET` each go to `ST_BUS_RESET` on a write with the reset bit set. Otherwise they go to `ST_SUSPENDED` on a write with the suspend bit set, and to `ST_IDLE` on any other write. Any state goes to `ST_OFF` when power will be off after the edge. Any powered state goes to `ST_IDLE` when ownership passes to the companion.

The block also decodes the raw D+/D- levels into a line-state hint. Software uses this hint to decide whether to release a newly attached low-speed device to the companion controller, or to go on with a high-speed reset. The bus-reset timing, test-pattern generation and the companion controller itself are outside this block.

Top module: `usb_port_ctrl_reg`

## Requirements
- R1: While reset is asserted, the read word has bit 13 (owner) set and every other bit clear. This holds with power switching present and the line state invalid. The companion-owner output is 1.
- R2: The owner bit (bit 13; 1 = companion owns the port) clears on the edge after the configure flag rises, and stays 0 while the flag is 0. Otherwise a write loads it from bit 13 of the written word.
- R3: With the power-switch capability input at 0, bit 12 reads 1 and the power output stays 1. Writes and overcurrent do not change this.
- R4: With the capability input at 1, bit 12 is read/write. The power output follows it one edge after the write.
- R5: With the capability input at 1, overcurrent on a powered port clears power at the next edge. This overrides a write of 1 in the same cycle.
- R6: Bits 11:10 show {D+, D-} in the same cycle when the port is disabled and connected. Otherwise they read 00.
- R7: The hint-valid output follows the same condition as R6. The release output is 1 only when the hint is valid and the lines read 01 (K state, low-speed device). The codes 00, 10 and 11 mean high-speed reset.
- R8: A write with bit 8 set, on a powered port, starts bus reset at the next edge. A powered write with bit 8 clear ends it. Bit 8 takes priority over bit 7 in the same write, so suspend then reads 0.
- R9: A powered write with bit 8 clear loads suspend from bit 7. Bus reset and suspend are never both 1.
- R10: Bits 8, 7 and 20 (wake on connect) read 0 while power is off, and writes to them are then ignored. An edge that removes power clears all three.
- R11: An edge at which the owner bit goes from 0 to 1 clears bus reset and suspend.
- R12: Bits 19:16 store any 4-bit test code. The test-mode output equals the stored code for 0 to 5 and 0 for the reserved codes 6 to 15.
- R13: Bits 31:21, 15:14 and 9, and bits 6:0, always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write word |
| rd_data_o | output | 32 | Read word |
| cfg_flag_i | input | 1 | Controller-wide configure flag |
| pwr_ctl_cap_i | input | 1 | Port power switch present |
| overcurrent_i | input | 1 | Overcurrent on this port |
| line_dp_i | input | 1 | Raw D+ level |
| line_dm_i | input | 1 | Raw D- level |
| connected_i | input | 1 | Device connected |
| enabled_i | input | 1 | Port enabled |
| pwr_sw_o | output | 1 | Port power switch on |
| bus_reset_o | output | 1 | Bus reset requested |
| suspend_o | output | 1 | Port suspended |
| wake_conn_o | output | 1 | Connect acts as wake-up event |
| companion_own_o | output | 1 | Companion controller owns port |
| test_mode_o | output | 4 | Active test mode, 0 when none |
| hint_valid_o | output | 1 | Line-state hint is valid |
| hint_release_o | output | 1 | Release port to companion (low-speed) |

## Verification
Line status and the two hint outputs are combinational, so they are due in the same cycle as the line inputs. Every register result (power, owner, bus reset, suspend, wake, test code) is due one rising edge after the cycle that carries the write, the configure-flag change or the overcurrent. The bench changes inputs on the falling edge and compares 1 ns later against a model. That model advances exactly once per rising edge, using the inputs just applied. A directed check on a write therefore looks at the cycle that follows it.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;

    localparam int unsigned REG_W        = 32;
    localparam int unsigned TEST_W       = 4;
    localparam int unsigned TEST_LAST_OK = 5;

    localparam int unsigned BIT_WAKE     = 20;
    localparam int unsigned TEST_LSB     = 16;
    localparam int unsigned BIT_OWNER    = 13;
    localparam int unsigned BIT_POWER    = 12;
    localparam int unsigned LINE_LSB     = 10;
    localparam int unsigned BIT_RESET    = 8;
    localparam int unsigned BIT_SUSPEND  = 7;

    localparam logic [1:0] LINE_K_STATE  = 2'b01;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_BUS_RESET,
        ST_SUSPENDED
    } port_state_e;

endpackage

// File: rtl/usb_port_owner.sv
module usb_port_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic owner_o,
    output logic owner_rise_o
);
    logic owner_q, owner_d, cfg_prev_q;

    always_comb begin
        if (!cfg_i)
            owner_d = 1'b0;
        else if (!cfg_prev_q)
            owner_d = 1'b0;
        else if (wr_i)
            owner_d = wr_bit_i;
        else
            owner_d = owner_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q    <= 1'b1;
            cfg_prev_q <= 1'b0;
        end else begin
            owner_q    <= owner_d;
            cfg_prev_q <= cfg_i;
        end
    end

    assign owner_o      = owner_q;
    assign owner_rise_o = owner_d & ~owner_q;
endmodule

// File: rtl/usb_port_power.sv
module usb_port_power (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    input  logic oc_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic pwr_now_o,
    output logic pwr_next_o
);
    logic pwr_q, pwr_d;

    always_comb begin
        pwr_d = pwr_q;
        if (cap_i) begin
            if (oc_i && pwr_q)
                pwr_d = 1'b0;
            else if (wr_i)
                pwr_d = wr_bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_q <= 1'b0;
        else
            pwr_q <= pwr_d;
    end

    assign pwr_now_o  = cap_i ? pwr_q : 1'b1;
    assign pwr_next_o = cap_i ? pwr_d : 1'b1;
endmodule

// File: rtl/usb_port_fsm.sv
module usb_port_fsm
    import usb_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_now_i,
    input  logic pwr_next_i,
    input  logic owner_rise_i,
    input  logic wr_i,
    input  logic wr_rst_i,
    input  logic wr_sus_i,
    input  logic wr_wake_i,
    output logic bus_rst_o,
    output logic suspend_o,
    output logic wake_o
);
    port_state_e state_q, state_d, state_cur;
    logic        wake_q, wake_d;

    // Next-state logic
    always_comb begin
        state_cur = (state_q == ST_OFF && pwr_now_i) ? ST_IDLE : state_q;
        state_d   = state_cur;
        if (!pwr_next_i) begin
            state_d = ST_OFF;
        end else if (owner_rise_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_cur)
                ST_OFF:
                    state_d = ST_IDLE;
                ST_IDLE, ST_SUSPENDED, ST_BUS_RESET:
                    if (wr_i) begin
                        if (wr_rst_i)
                            state_d = ST_BUS_RESET;
                        else if (wr_sus_i)
                            state_d = ST_SUSPENDED;
                        else
                            state_d = ST_IDLE;
                    end
            endcase
        end
    end

    always_comb begin
        if (!pwr_next_i)
            wake_d = 1'b0;
        else if (wr_i && pwr_now_i)
            wake_d = wr_wake_i;
        else
            wake_d = wake_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    // Outputs
    always_comb begin
        bus_rst_o = 1'b0;
        suspend_o = 1'b0;
        unique case (state_q)
            ST_OFF:       ;
            ST_IDLE:      ;
            ST_BUS_RESET: bus_rst_o = 1'b1;
            ST_SUSPENDED: suspend_o = 1'b1;
        endcase
    end

    assign wake_o = wake_q;
endmodule

// File: rtl/usb_port_testsel.sv
module usb_port_testsel #(
    parameter int unsigned CODE_W  = 4,
    parameter int unsigned LAST_OK = 5
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] mode_o
);
    localparam logic [CODE_W-1:0] LIMIT = CODE_W'(LAST_OK);

    assign mode_o = (code_i <= LIMIT) ? code_i : '0;
endmodule

// File: rtl/usb_port_ctrl_reg.sv
module usb_port_ctrl_reg
    import usb_port_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W,
    parameter int unsigned CODE_W = TEST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              cfg_flag_i,
    input  logic              pwr_ctl_cap_i,
    input  logic              overcurrent_i,
    input  logic              line_dp_i,
    input  logic              line_dm_i,
    input  logic              connected_i,
    input  logic              enabled_i,
    output logic              pwr_sw_o,
    output logic              bus_reset_o,
    output logic              suspend_o,
    output logic              wake_conn_o,
    output logic              companion_own_o,
    output logic [CODE_W-1:0] test_mode_o,
    output logic              hint_valid_o,
    output logic              hint_release_o
);
    logic              pwr_now, pwr_next, owner_rise;
    logic [CODE_W-1:0] test_q;
    logic [1:0]        line_bits;
    logic              line_ok;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data_i;

    usb_port_owner u_owner (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_i        (cfg_flag_i),
        .wr_i         (wr_en_i),
        .wr_bit_i     (wr_data_i[BIT_OWNER]),
        .owner_o      (companion_own_o),
        .owner_rise_o (owner_rise)
    );

    usb_port_power u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (pwr_ctl_cap_i),
        .oc_i       (overcurrent_i),
        .wr_i       (wr_en_i),
        .wr_bit_i   (wr_data_i[BIT_POWER]),
        .pwr_now_o  (pwr_now),
        .pwr_next_o (pwr_next)
    );

    usb_port_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_now_i    (pwr_now),
        .pwr_next_i   (pwr_next),
        .owner_rise_i (owner_rise),
        .wr_i         (wr_en_i),
        .wr_rst_i     (wr_data_i[BIT_RESET]),
        .wr_sus_i     (wr_data_i[BIT_SUSPEND]),
        .wr_wake_i    (wr_data_i[BIT_WAKE]),
        .bus_rst_o    (bus_reset_o),
        .suspend_o    (suspend_o),
        .wake_o       (wake_conn_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            test_q <= '0;
        else if (wr_en_i)
            test_q <= wr_data_i[TEST_LSB +: CODE_W];
    end

    usb_port_testsel #(
        .CODE_W  (CODE_W),
        .LAST_OK (TEST_LAST_OK)
    ) u_testsel (
        .code_i (test_q),
        .mode_o (test_mode_o)
    );

    // Line-state hint (combinational)
    assign line_ok        = connected_i & ~enabled_i;
    assign line_bits      = line_ok ? {line_dp_i, line_dm_i} : 2'b00;
    assign hint_valid_o   = line_ok;
    assign hint_release_o = line_ok && (line_bits == LINE_K_STATE);
    assign pwr_sw_o       = pwr_now;

    always_comb begin
        rd_data_o                      = '0;
        rd_data_o[BIT_WAKE]            = wake_conn_o;
        rd_data_o[TEST_LSB +: CODE_W]  = test_q;
        rd_data_o[BIT_OWNER]           = companion_own_o;
        rd_data_o[BIT_POWER]           = pwr_now;
        rd_data_o[LINE_LSB +: 2]       = line_bits;
        rd_data_o[BIT_RESET]           = bus_reset_o;
        rd_data_o[BIT_SUSPEND]         = suspend_o;
    end
endmodule

// File: rtl/usb_port_ctrl_reg_chk.sv
module usb_port_ctrl_reg_chk
    import usb_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_flag_i,
    input logic              pwr_ctl_cap_i,
    input logic              overcurrent_i,
    input logic              pwr_sw_o,
    input logic              bus_reset_o,
    input logic              suspend_o,
    input logic              wake_conn_o,
    input logic              companion_own_o,
    input logic [TEST_W-1:0] test_mode_o,
    input logic              hint_valid_o,
    input logic              hint_release_o
);
    p_owner_cfg_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_flag_i |=> !companion_own_o);

    p_owner_cfg_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_flag_i) |=> !companion_own_o);

    p_pwr_hardwired_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ctl_cap_i |-> pwr_sw_o);

    p_oc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ctl_cap_i && pwr_sw_o && overcurrent_i) |=> (!pwr_sw_o || !pwr_ctl_cap_i));

    p_hint_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hint_release_o |-> hint_valid_o);

    p_rst_sus_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_reset_o && suspend_o));

    p_off_gating_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_sw_o |-> (!bus_reset_o && !suspend_o && !wake_conn_o));

    p_owner_rise_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(companion_own_o) |-> (!bus_reset_o && !suspend_o));

    p_test_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_o <= TEST_W'(TEST_LAST_OK));
endmodule

bind usb_port_ctrl_reg usb_port_ctrl_reg_chk u_chk (.*);

// File: tb/sim_usb_port_ctrl_reg.sv
`timescale 1ns/100ps
module sim_usb_port_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cfg = 1'b0, cap = 1'b1, oc = 1'b0, dp = 1'b0, dm = 1'b0, conn = 1'b0, en = 1'b0;
    logic        pwr_sw, bus_reset, suspend, wake, owner, hint_valid, hint_release;
    logic [3:0]  test_mode;

    // next-cycle inputs, applied on the falling edge
    logic nx_cfg = 1'b0, nx_cap = 1'b1, nx_oc = 1'b0, nx_dp = 1'b0, nx_dm = 1'b0, nx_conn = 1'b0, nx_en = 1'b0;

    // model state
    logic       m_pwr, m_own, m_cfgp, m_rst, m_sus, m_wake;
    logic [3:0] m_test;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [31:0] P = 32'h1 << 12, O = 32'h1 << 13, R = 32'h1 << 8,
                            S = 32'h1 << 7, W = 32'h1 << 20;

    always #2.5 clk = ~clk;

    usb_port_ctrl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .cfg_flag_i(cfg), .pwr_ctl_cap_i(cap), .overcurrent_i(oc), .line_dp_i(dp), .line_dm_i(dm),
        .connected_i(conn), .enabled_i(en), .pwr_sw_o(pwr_sw), .bus_reset_o(bus_reset),
        .suspend_o(suspend), .wake_conn_o(wake), .companion_own_o(owner), .test_mode_o(test_mode),
        .hint_valid_o(hint_valid), .hint_release_o(hint_release)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        logic [31:0] v = '0;
        logic lv = conn && !en;
        v[20]    = m_wake;
        v[19:16] = m_test;
        v[13]    = m_own;
        v[12]    = cap ? m_pwr : 1'b1;
        v[11:10] = lv ? {dp, dm} : 2'b00;
        v[8]     = m_rst;
        v[7]     = m_sus;
        return v;
    endfunction

    task automatic compare_all();
        logic lv = conn && !en;
        chk("R13 read word", rd_data, exp_rd());
        chk(cap ? "R4 power" : "R3 power", {31'b0, pwr_sw}, {31'b0, cap ? m_pwr : 1'b1});
        chk("R8 bus reset", {31'b0, bus_reset}, {31'b0, m_rst});
        chk("R9 suspend", {31'b0, suspend}, {31'b0, m_sus});
        chk("R10 wake", {31'b0, wake}, {31'b0, m_wake});
        chk("R2 owner", {31'b0, owner}, {31'b0, m_own});
        chk("R12 test mode", {28'b0, test_mode}, {28'b0, (m_test <= 4'd5) ? m_test : 4'd0});
        chk("R7 hint valid", {31'b0, hint_valid}, {31'b0, lv});
        chk("R7 hint release", {31'b0, hint_release}, {31'b0, lv && {dp, dm} == 2'b01});
    endtask

    task automatic model_step();
        logic pn, pnext, own_n, rise;
        pn    = cap ? m_pwr : 1'b1;
        pnext = 1'b1;
        if (cap) begin
            if (oc && m_pwr)  pnext = 1'b0;
            else if (wr_en)   pnext = wr_data[12];
            else              pnext = m_pwr;
            m_pwr = pnext;
        end
        if (!cfg || !m_cfgp) own_n = 1'b0;
        else if (wr_en)      own_n = wr_data[13];
        else                 own_n = m_own;
        rise = own_n && !m_own;
        if (!pnext || rise) begin
            m_rst = 1'b0; m_sus = 1'b0;
        end else if (wr_en && pn) begin
            m_rst = wr_data[8];
            m_sus = !wr_data[8] && wr_data[7];
        end
        if (!pnext)              m_wake = 1'b0;
        else if (wr_en && pn)    m_wake = wr_data[20];
        if (wr_en) m_test = wr_data[19:16];
        m_own  = own_n;
        m_cfgp = cfg;
    endtask

    task automatic apply_nx();
        cfg = nx_cfg; cap = nx_cap; oc = nx_oc; dp = nx_dp; dm = nx_dm; conn = nx_conn; en = nx_en;
    endtask

    task automatic drive(input logic w, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; wr_data = d; apply_nx();
        #1;
        compare_all();
        model_step();
    endtask

    task automatic do_reset(input logic c);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        nx_cap = c; nx_cfg = 1'b0; nx_oc = 1'b0; nx_conn = 1'b0; nx_en = 1'b0;
        apply_nx();
        m_pwr = 1'b0; m_own = 1'b1; m_cfgp = 1'b0; m_rst = 1'b0; m_sus = 1'b0;
        m_wake = 1'b0; m_test = '0;
        repeat (2) @(negedge clk);
        #1;
        compare_all();
        chk("R1 reset word", rd_data, c ? 32'h0000_2000 : 32'h0000_3000);
        chk("R1 owner out", {31'b0, owner}, 32'd1);
        rst_n = 1'b1;
        model_step();
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] d;
            if ($urandom % 16 == 0) nx_cfg = !nx_cfg;
            nx_oc   = ($urandom % 12) == 0;
            nx_dp   = $urandom % 2;
            nx_dm   = $urandom % 2;
            nx_conn = $urandom % 2;
            nx_en   = $urandom % 2;
            d       = $urandom;
            d[12]   = ($urandom % 4) != 0;
            drive(($urandom % 3) == 0, d);
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        // ---- power switching present ----
        do_reset(1'b1);
        drive(1'b0, '0);
        chk("R2 owner cleared while cfg low", {31'b0, owner}, 32'd0);
        nx_cfg = 1'b1;
        drive(1'b1, P | R | O);            // cfg rises; power off so reset ignored
        drive(1'b0, '0);
        chk("R4 power on after write", {31'b0, pwr_sw}, 32'd1);
        chk("R10 reset write ignored while off", {31'b0, bus_reset}, 32'd0);
        chk("R2 owner write lost on cfg rise", {31'b0, owner}, 32'd0);
        drive(1'b1, P | R);
        drive(1'b0, '0);
        chk("R8 bus reset started", {31'b0, bus_reset}, 32'd1);
        drive(1'b1, P | R | S);
        drive(1'b0, '0);
        chk("R8 reset over suspend", {30'b0, bus_reset, suspend}, 32'd2);
        drive(1'b1, P | S);
        drive(1'b0, '0);
        chk("R9 suspend set, reset ended", {30'b0, bus_reset, suspend}, 32'd1);
        drive(1'b1, P | S | O);
        drive(1'b0, '0);
        chk("R11 owner rise clears suspend", {30'b0, owner, suspend}, 32'd2);
        drive(1'b1, P | R | W);
        drive(1'b0, '0);
        chk("R2 owner written 0", {31'b0, owner}, 32'd0);
        chk("R8 reset and R10 wake set", {30'b0, bus_reset, wake}, 32'd3);
        nx_oc = 1'b1;
        drive(1'b1, P | R | W);
        nx_oc = 1'b0;
        drive(1'b0, '0);
        chk("R5 overcurrent clears power", {31'b0, pwr_sw}, 32'd0);
        chk("R10 power loss clears fields", {29'b0, bus_reset, suspend, wake}, 32'd0);
        drive(1'b1, R | S | W);
        drive(1'b0, '0);
        chk("R10 writes ignored while off", rd_data & (R | S | W), 32'd0);
        drive(1'b1, 32'h7 << 16);
        drive(1'b0, '0);
        chk("R12 reserved code stored", {28'b0, rd_data[19:16]}, 32'd7);
        chk("R12 reserved code reports none", {28'b0, test_mode}, 32'd0);
        drive(1'b1, (32'h3 << 16) | P);
        drive(1'b0, '0);
        chk("R12 legal code", {28'b0, test_mode}, 32'd3);
        nx_conn = 1'b1; nx_en = 1'b0; nx_dp = 1'b0; nx_dm = 1'b1;
        drive(1'b0, '0);
        chk("R6 K state on lines", {30'b0, rd_data[11:10]}, 32'd1);
        chk("R7 low-speed release", {30'b0, hint_valid, hint_release}, 32'd3);
        nx_dp = 1'b1; nx_dm = 1'b0;
        drive(1'b0, '0);
        chk("R7 J state no release", {30'b0, hint_valid, hint_release}, 32'd2);
        nx_en = 1'b1;
        drive(1'b0, '0);
        chk("R6 enabled port hides lines", {30'b0, rd_data[11:10]}, 32'd0);
        drive(1'b1, 32'hFFFF_FFFF);
        drive(1'b0, '0);
        chk("R13 unused bits zero", rd_data & ~(W | (32'hF << 16) | O | P | (32'h3 << 10) | R | S), 32'd0);
        nx_cfg = 1'b0;
        drive(1'b1, P | O);
        drive(1'b0, '0);
        chk("R2 owner held 0 with cfg low", {31'b0, owner}, 32'd0);
        random_run(3000);
        // ---- power hard-wired ----
        do_reset(1'b0);
        nx_oc = 1'b1;
        drive(1'b1, '0);
        nx_oc = 1'b0;
        drive(1'b0, '0);
        chk("R3 power stays on", {31'b0, pwr_sw, rd_data[12]} , 32'd3);
        random_run(1500);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule